// File: doc/BRIEF.md
# Fairness-aware DRAM request scheduler

This block chooses which pending memory request goes to the DRAM next. It looks at a buffer of requests that several hardware threads share. Each entry carries a valid bit, the issuing thread, the target bank, the target row and a wrapping age stamp. The scheduler also sees which row is open in each bank. A separate tracker supplies a per-thread slowdown value in unsigned fixed point. When a `pick` strobe is given, the scheduler registers a grant strobe and the index of the winning entry, one cycle later.

There are two orderings. The throughput ordering serves row-buffer hits before conflicts, and the oldest request before younger ones. The fairness ordering first serves requests from the most-slowed-down thread. Within that thread, and among all threads when that thread has nothing pending, it still uses hit first and then oldest. Unfairness is the largest slowdown divided by the smallest slowdown. It is compared against a threshold that software programs. The ordering and the favoured thread are sampled on each scheduling-epoch strobe and held until the next one.

Top module: `fair_dram_sched`

## Requirements
- R1: After reset, `grant` is 0, `grant_idx` is 0, the threshold equals `ALPHA_INIT`, and the throughput ordering is in force until the first epoch strobe.
- R2: A `pick` while no entry is valid leaves `grant` at 0 in the following cycle.
- R3: A `pick` while at least one entry is valid raises `grant` for exactly the next cycle. `grant_idx` then names an entry that was valid at the pick. Without a `pick`, `grant` is 0 and `grant_idx` is 0.
- R4: Under the throughput ordering, an entry that hits wins over every entry that conflicts. An entry hits when its bank is open and the open row of that bank equals the entry's row.
- R5: Among entries of equal priority class, the oldest wins. Ages are compared modulo 2^AGE_W: stamp a is older than stamp b when (b - a) mod 2^AGE_W lies in 1 .. 2^(AGE_W-1)-1. All valid stamps must lie within half that range of one another.
- R6: Entries equal in class and in age are resolved in favour of the lowest buffer index.
- R7: On an epoch strobe the fairness ordering is chosen when max_slowdown * 2^SLOW_FRAC >= alpha * min_slowdown. Equality counts as unfair. Otherwise the throughput ordering is chosen. Slowdown and alpha are unsigned with SLOW_FRAC fraction bits.
- R8: Under the fairness ordering, entries of the favoured thread win over all others. The favoured thread is the one with the largest slowdown at the epoch, the lowest thread number on a tie. Inside that thread, R4, R5 and R6 apply.
- R9: Under the fairness ordering, when the favoured thread has no valid entry, the choice is the same as under the throughput ordering.
- R10: The ordering and the favoured thread change only on an epoch strobe. A `pick` in the same cycle as an epoch strobe uses the previous ordering.
- R11: A write strobe loads the threshold, and the next epoch decision uses the new value.
- R12: An entry whose bank is closed never counts as a hit, even when the stored row matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_alpha_we | input | 1 | Threshold write strobe |
| cfg_alpha_wdata | input | SLOW_W | New threshold, SLOW_FRAC fraction bits |
| sched_epoch | input | 1 | Start of a scheduling epoch: latch the ordering and the favoured thread |
| pick | input | 1 | Request one scheduling decision |
| req_valid | input | NUM_ENTRIES | Per-entry valid bits |
| req_thread | input | NUM_ENTRIES*TID_W | Per-entry thread number |
| req_bank | input | NUM_ENTRIES*BANK_W | Per-entry bank number |
| req_row | input | NUM_ENTRIES*ROW_W | Per-entry row number |
| req_age | input | NUM_ENTRIES*AGE_W | Per-entry wrapping age stamp |
| bank_open | input | NUM_BANKS | Bank has an open row |
| bank_row | input | NUM_BANKS*ROW_W | Open row of each bank |
| thr_slowdown | input | NUM_THREADS*SLOW_W | Per-thread slowdown, fixed point |
| grant | output | 1 | One-cycle grant strobe |
| grant_idx | output | IDX_W | Index of the granted entry |

## Verification
Directed patterns put one young hit against old conflicts, which separates row-hit priority from age priority. They put the same row behind a closed bank, which separates a row match from a real hit. They set age stamps on both sides of the wrap point and equal stamps at different indices, which exposes plain or signed age comparison and a wrong tie order. Slowdown sets just below, exactly at and above the threshold show whether the comparison is inclusive. A favoured thread with a conflict, with a hit, and with nothing pending shows whether thread priority sits above hit priority and how the ordering falls back. Epoch strobes issued with, before and without a pick, together with randomized buffers checked against a behavioural model every clock, show when the ordering is latched.

// File: rtl/fsched_pkg.sv
package fsched_pkg;
   typedef enum logic {
      POL_THRU = 1'b0,
      POL_FAIR = 1'b1
   } pol_e;

   typedef struct packed {
      logic fav;
      logic hit;
   } rank_t;
endpackage

// File: rtl/fsched_unfair_det.sv
module fsched_unfair_det #(
   parameter int NUM_THREADS = 4,
   parameter int SLOW_W      = 16,
   parameter int SLOW_FRAC   = 8,
   parameter int TID_W       = 2
) (
   input  logic [NUM_THREADS*SLOW_W-1:0] slowdown,
   input  logic [SLOW_W-1:0]             alpha,
   output logic                          unfair,
   output logic [TID_W-1:0]              max_tid
);
   localparam int PW = 2 * SLOW_W;

   logic [SLOW_W-1:0] max_s;
   logic [SLOW_W-1:0] min_s;
   logic [PW-1:0]     lhs;
   logic [PW-1:0]     rhs;

   always_comb begin
      max_s   = slowdown[0 +: SLOW_W];
      min_s   = slowdown[0 +: SLOW_W];
      max_tid = '0;
      for (int t = 1; t < NUM_THREADS; t++) begin
         if (slowdown[t*SLOW_W +: SLOW_W] > max_s) begin
            max_s   = slowdown[t*SLOW_W +: SLOW_W];
            max_tid = TID_W'(t);
         end
         if (slowdown[t*SLOW_W +: SLOW_W] < min_s) begin
            min_s = slowdown[t*SLOW_W +: SLOW_W];
         end
      end
   end

   // ratio test without a divider: max/min >= alpha  <=>  max*2^F >= alpha*min
   assign lhs    = PW'(max_s) << SLOW_FRAC;
   assign rhs    = PW'(alpha) * PW'(min_s);
   assign unfair = (lhs >= rhs);
endmodule

// File: rtl/fsched_classify.sv
module fsched_classify #(
   parameter int NUM_ENTRIES = 16,
   parameter int NUM_BANKS   = 8,
   parameter int BANK_W      = 3,
   parameter int ROW_W       = 14,
   parameter int TID_W       = 2
) (
   input  logic [NUM_ENTRIES*TID_W-1:0]  req_thread,
   input  logic [NUM_ENTRIES*BANK_W-1:0] req_bank,
   input  logic [NUM_ENTRIES*ROW_W-1:0]  req_row,
   input  logic [NUM_BANKS-1:0]          bank_open,
   input  logic [NUM_BANKS*ROW_W-1:0]    bank_row,
   input  logic                          fav_en,
   input  logic [TID_W-1:0]              fav_tid,
   output logic [NUM_ENTRIES-1:0]        hit,
   output logic [NUM_ENTRIES-1:0]        fav
);
   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
      logic [ROW_W-1:0] row_i;
      assign row_i  = req_row[i*ROW_W +: ROW_W];
      assign fav[i] = fav_en && (req_thread[i*TID_W +: TID_W] == fav_tid);

      if (NUM_BANKS == 1) begin : g_single
         logic [BANK_W-1:0] bank_unused;
         assign bank_unused = req_bank[i*BANK_W +: BANK_W];
         assign hit[i] = bank_open[0] && (bank_row[ROW_W-1:0] == row_i);
      end else begin : g_multi
         logic [BANK_W-1:0] b;
         always_comb begin
            b      = req_bank[i*BANK_W +: BANK_W];
            hit[i] = 1'b0;
            for (int k = 0; k < NUM_BANKS; k++) begin
               if (b == BANK_W'(k)) begin
                  hit[i] = bank_open[k] && (bank_row[k*ROW_W +: ROW_W] == row_i);
               end
            end
         end
      end
   end
endmodule

// File: rtl/fsched_select.sv
module fsched_select
   import fsched_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int AGE_W       = 8,
   parameter int IDX_W       = 4
) (
   input  logic [NUM_ENTRIES-1:0]       valid,
   input  logic [NUM_ENTRIES-1:0]       hit,
   input  logic [NUM_ENTRIES-1:0]       fav,
   input  logic [NUM_ENTRIES*AGE_W-1:0] age,
   output logic                         any,
   output logic [IDX_W-1:0]             best_idx
);
   // a is strictly older than b within a half-range window
   function automatic logic is_older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
      logic [AGE_W-1:0] d;
      d = b - a;
      return (d != '0) && !d[AGE_W-1];
   endfunction

   rank_t            rank [NUM_ENTRIES];
   rank_t            best_rank;
   logic [AGE_W-1:0] best_age;

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_rank
      assign rank[i] = '{fav: fav[i], hit: hit[i]};
   end

   always_comb begin
      any       = 1'b0;
      best_idx  = '0;
      best_rank = '0;
      best_age  = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (valid[i]) begin
            if (!any || (rank[i] > best_rank) ||
                ((rank[i] == best_rank) && is_older(age[i*AGE_W +: AGE_W], best_age))) begin
               any       = 1'b1;
               best_idx  = IDX_W'(i);
               best_rank = rank[i];
               best_age  = age[i*AGE_W +: AGE_W];
            end
         end
      end
   end
endmodule

// File: rtl/fair_dram_sched.sv
module fair_dram_sched
   import fsched_pkg::*;
#(
   parameter int            NUM_ENTRIES = 16,
   parameter int            NUM_THREADS = 4,
   parameter int            NUM_BANKS   = 8,
   parameter int            ROW_W       = 14,
   parameter int            AGE_W       = 8,
   parameter int            SLOW_W      = 16,
   parameter int            SLOW_FRAC   = 8,
   parameter logic [SLOW_W-1:0] ALPHA_INIT = SLOW_W'(2 << SLOW_FRAC),
   localparam int           IDX_W  = $clog2(NUM_ENTRIES),
   localparam int           TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
   localparam int           BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_alpha_we,
   input  logic [SLOW_W-1:0]             cfg_alpha_wdata,
   input  logic                          sched_epoch,
   input  logic                          pick,
   input  logic [NUM_ENTRIES-1:0]        req_valid,
   input  logic [NUM_ENTRIES*TID_W-1:0]  req_thread,
   input  logic [NUM_ENTRIES*BANK_W-1:0] req_bank,
   input  logic [NUM_ENTRIES*ROW_W-1:0]  req_row,
   input  logic [NUM_ENTRIES*AGE_W-1:0]  req_age,
   input  logic [NUM_BANKS-1:0]          bank_open,
   input  logic [NUM_BANKS*ROW_W-1:0]    bank_row,
   input  logic [NUM_THREADS*SLOW_W-1:0] thr_slowdown,
   output logic                          grant,
   output logic [IDX_W-1:0]              grant_idx
);
   if (NUM_ENTRIES < 2) begin : g_chk_entries
      $error("NUM_ENTRIES must be at least 2");
   end
   if (AGE_W < 2) begin : g_chk_age
      $error("AGE_W must be at least 2");
   end
   if (SLOW_FRAC >= SLOW_W) begin : g_chk_frac
      $error("SLOW_FRAC must be below SLOW_W");
   end
   if (ROW_W < 1 || NUM_BANKS < 1 || NUM_THREADS < 1) begin : g_chk_misc
      $error("ROW_W, NUM_BANKS and NUM_THREADS must be positive");
   end

   logic [SLOW_W-1:0]      alpha_q;
   pol_e                   mode_q;
   logic [TID_W-1:0]       fav_q;
   logic                   unfair_now;
   logic [TID_W-1:0]       max_tid_now;
   logic [NUM_ENTRIES-1:0] entry_hit;
   logic [NUM_ENTRIES-1:0] entry_fav;
   logic                   sel_any;
   logic [IDX_W-1:0]       sel_idx;

   fsched_unfair_det #(
      .NUM_THREADS (NUM_THREADS),
      .SLOW_W      (SLOW_W),
      .SLOW_FRAC   (SLOW_FRAC),
      .TID_W       (TID_W)
   ) u_unfair (
      .slowdown (thr_slowdown),
      .alpha    (alpha_q),
      .unfair   (unfair_now),
      .max_tid  (max_tid_now)
   );

   fsched_classify #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .NUM_BANKS   (NUM_BANKS),
      .BANK_W      (BANK_W),
      .ROW_W       (ROW_W),
      .TID_W       (TID_W)
   ) u_classify (
      .req_thread (req_thread),
      .req_bank   (req_bank),
      .req_row    (req_row),
      .bank_open  (bank_open),
      .bank_row   (bank_row),
      .fav_en     (mode_q == POL_FAIR),
      .fav_tid    (fav_q),
      .hit        (entry_hit),
      .fav        (entry_fav)
   );

   fsched_select #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .AGE_W       (AGE_W),
      .IDX_W       (IDX_W)
   ) u_select (
      .valid    (req_valid),
      .hit      (entry_hit),
      .fav      (entry_fav),
      .age      (req_age),
      .any      (sel_any),
      .best_idx (sel_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alpha_q <= ALPHA_INIT;
      end else if (cfg_alpha_we) begin
         alpha_q <= cfg_alpha_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= POL_THRU;
         fav_q  <= '0;
      end else if (sched_epoch) begin
         mode_q <= unfair_now ? POL_FAIR : POL_THRU;
         fav_q  <= max_tid_now;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant     <= 1'b0;
         grant_idx <= '0;
      end else begin
         grant     <= pick && sel_any;
         grant_idx <= (pick && sel_any) ? sel_idx : '0;
      end
   end
endmodule

// File: rtl/fsched_chk.sv
module fsched_chk
   import fsched_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int IDX_W       = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   pick,
   input logic                   sched_epoch,
   input logic [NUM_ENTRIES-1:0] req_valid,
   input logic [NUM_ENTRIES-1:0] hit,
   input pol_e                   mode_q,
   input logic                   grant,
   input logic [IDX_W-1:0]       grant_idx
);
   logic [NUM_ENTRIES-1:0] vld_d;
   logic [NUM_ENTRIES-1:0] hit_d;
   pol_e                   mode_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_d  <= '0;
         hit_d  <= '0;
         mode_d <= POL_THRU;
      end else begin
         vld_d  <= req_valid;
         hit_d  <= hit;
         mode_d <= mode_q;
      end
   end

   a_r2_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (pick && !(|req_valid)) |=> !grant);

   a_r3_pick_served: assert property (@(posedge clk) disable iff (!rst_n)
      (pick && (|req_valid)) |=> grant);

   a_r3_grant_needs_pick: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> $past(pick));

   a_r3_granted_valid: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> vld_d[grant_idx]);

   a_r4_hit_preferred: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && (mode_d == POL_THRU) && (|(vld_d & hit_d))) |-> hit_d[grant_idx]);

   a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      !sched_epoch |=> $stable(mode_q));
endmodule

bind fair_dram_sched fsched_chk #(
   .NUM_ENTRIES (NUM_ENTRIES),
   .IDX_W       (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pick        (pick),
   .sched_epoch (sched_epoch),
   .req_valid   (req_valid),
   .hit         (entry_hit),
   .mode_q      (mode_q),
   .grant       (grant),
   .grant_idx   (grant_idx)
);

// File: tb/fair_dram_sched_bench.sv
module fair_dram_sched_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NE  = 16;
   localparam int NT  = 4;
   localparam int NB  = 8;
   localparam int RW  = 14;
   localparam int AW  = 8;
   localparam int SW  = 16;
   localparam int SF  = 8;
   localparam int IW  = 4;
   localparam int TW  = 2;
   localparam int BW  = 3;
   localparam int AMASK = (1 << AW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_alpha_we = 1'b0;
   logic [SW-1:0] cfg_alpha_wdata = '0;
   logic sched_epoch = 1'b0;
   logic pick = 1'b0;
   logic [NE-1:0]    req_valid;
   logic [NE*TW-1:0] req_thread;
   logic [NE*BW-1:0] req_bank;
   logic [NE*RW-1:0] req_row;
   logic [NE*AW-1:0] req_age;
   logic [NB-1:0]    bank_open;
   logic [NB*RW-1:0] bank_row;
   logic [NT*SW-1:0] thr_slowdown;
   logic             grant;
   logic [IW-1:0]    grant_idx;

   int e_vld [NE];
   int e_thr [NE];
   int e_bank[NE];
   int e_row [NE];
   int e_age [NE];
   int b_open[NB];
   int b_row [NB];
   int slow  [NT];

   int    n_checks = 0;
   int    n_fail   = 0;
   string cur_tag  = "R3";
   bit    done     = 1'b0;

   // reference model state
   int exp_grant, exp_idx, exp_mode, exp_fav, exp_alpha;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < NE; i++) begin
         req_valid[i]              = (e_vld[i] != 0);
         req_thread[i*TW +: TW]    = TW'(e_thr[i]);
         req_bank[i*BW +: BW]      = BW'(e_bank[i]);
         req_row[i*RW +: RW]       = RW'(e_row[i]);
         req_age[i*AW +: AW]       = AW'(e_age[i]);
      end
      for (int b = 0; b < NB; b++) begin
         bank_open[b]         = (b_open[b] != 0);
         bank_row[b*RW +: RW] = RW'(b_row[b]);
      end
      for (int t = 0; t < NT; t++) thr_slowdown[t*SW +: SW] = SW'(slow[t]);
   end

   fair_dram_sched u_fair_dram_sched (
      .clk             (clk),
      .rst_n           (rst_n),
      .cfg_alpha_we    (cfg_alpha_we),
      .cfg_alpha_wdata (cfg_alpha_wdata),
      .sched_epoch     (sched_epoch),
      .pick            (pick),
      .req_valid       (req_valid),
      .req_thread      (req_thread),
      .req_bank        (req_bank),
      .req_row         (req_row),
      .req_age         (req_age),
      .bank_open       (bank_open),
      .bank_row        (bank_row),
      .thr_slowdown    (thr_slowdown),
      .grant           (grant),
      .grant_idx       (grant_idx)
   );

   function automatic bit ref_older(int a, int b);
      int d;
      d = (b - a) & AMASK;
      return (d >= 1) && (d <= (AMASK >> 1));
   endfunction

   function automatic int ref_class(int i, int mode, int fv);
      int c;
      c = 0;
      if (e_bank[i] < NB && b_open[e_bank[i]] != 0 && b_row[e_bank[i]] == e_row[i]) c += 1;
      if (mode != 0 && e_thr[i] == fv) c += 2;
      return c;
   endfunction

   // behavioural choice: best class first, then an entry nobody in that class beats on age
   function automatic int ref_pick(int mode, int fv);
      int top;
      top = -1;
      for (int i = 0; i < NE; i++)
         if (e_vld[i] != 0 && ref_class(i, mode, fv) > top) top = ref_class(i, mode, fv);
      if (top < 0) return -1;
      for (int c = 0; c < NE; c++) begin
         bit beaten;
         if (e_vld[c] == 0 || ref_class(c, mode, fv) != top) continue;
         beaten = 1'b0;
         for (int d = 0; d < NE; d++)
            if (d != c && e_vld[d] != 0 && ref_class(d, mode, fv) == top && ref_older(e_age[d], e_age[c]))
               beaten = 1'b1;
         if (!beaten) return c;
      end
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         exp_grant <= 0; exp_idx <= 0; exp_mode <= 0; exp_fav <= 0; exp_alpha <= 512;
      end else begin
         int p;
         p = pick ? ref_pick(exp_mode, exp_fav) : -1;
         exp_grant <= (p >= 0) ? 1 : 0;
         exp_idx   <= (p >= 0) ? p : 0;
         if (sched_epoch) begin
            longint mx, mn;
            int     mt;
            mx = slow[0]; mn = slow[0]; mt = 0;
            for (int t = 1; t < NT; t++) begin
               if (slow[t] > mx) begin mx = slow[t]; mt = t; end
               if (slow[t] < mn) mn = slow[t];
            end
            exp_mode <= ((mx << SF) >= longint'(exp_alpha) * mn) ? 1 : 0;
            exp_fav  <= mt;
         end
         if (cfg_alpha_we) exp_alpha <= int'(cfg_alpha_wdata);
      end
   end

   task automatic check(string tag, int act, int expv);
      n_checks++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({cur_tag, " grant (model)"}, int'(grant), exp_grant);
         check({cur_tag, " grant_idx (model)"}, int'(grant_idx), exp_idx);
      end
   end

   task automatic clear_entries();
      for (int i = 0; i < NE; i++) begin
         e_vld[i] = 0; e_thr[i] = 0; e_bank[i] = 0; e_row[i] = 0; e_age[i] = 0;
      end
   endtask

   task automatic set_e(int i, int thr, int bank, int row, int age);
      e_vld[i] = 1; e_thr[i] = thr; e_bank[i] = bank; e_row[i] = row; e_age[i] = age;
   endtask

   task automatic set_slow(int s0, int s1, int s2, int s3);
      slow[0] = s0; slow[1] = s1; slow[2] = s2; slow[3] = s3;
   endtask

   task automatic do_pick();
      pick = 1'b1;
      @(negedge clk);
      pick = 1'b0;
   endtask

   task automatic do_epoch();
      sched_epoch = 1'b1;
      @(negedge clk);
      sched_epoch = 1'b0;
   endtask

   task automatic write_alpha(int v);
      cfg_alpha_we = 1'b1; cfg_alpha_wdata = SW'(v);
      @(negedge clk);
      cfg_alpha_we = 1'b0;
   endtask

   task automatic expect_grant(string tag, int idx);
      check({tag, " grant"}, int'(grant), 1);
      check({tag, " grant_idx"}, int'(grant_idx), idx);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      clear_entries();
      for (int b = 0; b < NB; b++) begin b_open[b] = 0; b_row[b] = 0; end
      set_slow(256, 256, 256, 256);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      cur_tag = "R1";
      check("R1 grant after reset", int'(grant), 0);
      check("R1 grant_idx after reset", int'(grant_idx), 0);
      // R1: throughput ordering without an epoch even though thread 1 is much slower
      set_slow(256, 1000, 256, 256);
      b_open[2] = 1; b_row[2] = 33;
      set_e(0, 1, 2, 40, 1);
      set_e(3, 0, 2, 33, 9);
      do_pick();
      expect_grant("R1 throughput at reset", 3);
      // R1/R7: default threshold 2.0, ratio just below
      set_slow(256, 509, 256, 256);
      do_epoch();
      do_pick();
      expect_grant("R1 default alpha below threshold", 3);
      // R7: exactly at threshold counts as unfair
      cur_tag = "R7";
      set_slow(256, 512, 256, 256);
      do_epoch();
      do_pick();
      expect_grant("R7 ratio equal to alpha", 0);

      // R2: nothing valid
      cur_tag = "R2";
      clear_entries();
      do_pick();
      check("R2 no grant when empty", int'(grant), 0);

      // R3: no pick, no grant
      cur_tag = "R3";
      set_e(4, 0, 0, 0, 0);
      @(negedge clk);
      check("R3 idle without pick", int'(grant), 0);
      check("R3 idle index", int'(grant_idx), 0);

      // R4: young hit beats old conflict
      cur_tag = "R4";
      set_slow(256, 256, 256, 256);
      do_epoch();
      clear_entries();
      b_open[1] = 1; b_row[1] = 20;
      set_e(2, 0, 1, 10, 5);
      set_e(5, 2, 1, 20, 9);
      do_pick();
      expect_grant("R4 hit first", 5);

      // R12: closed bank gives no hit
      cur_tag = "R12";
      b_open[1] = 0;
      do_pick();
      expect_grant("R12 closed bank", 2);

      // R5: wrapping ages
      cur_tag = "R5";
      clear_entries();
      b_open[3] = 1; b_row[3] = 7;
      set_e(2, 0, 3, 7, 250);
      set_e(7, 1, 3, 7, 3);
      do_pick();
      expect_grant("R5 older across wrap", 2);
      e_age[2] = 3; e_age[7] = 250;
      do_pick();
      expect_grant("R5 older across wrap swapped", 7);

      // R6: equal class and age
      cur_tag = "R6";
      clear_entries();
      set_e(9, 1, 3, 7, 40);
      set_e(4, 2, 3, 7, 40);
      do_pick();
      expect_grant("R6 lowest index", 4);

      // R8: favoured thread 2
      cur_tag = "R8";
      set_slow(300, 300, 900, 300);
      do_epoch();
      clear_entries();
      set_e(0, 0, 3, 7, 1);
      set_e(6, 2, 3, 99, 10);
      set_e(8, 2, 3, 7, 20);
      do_pick();
      expect_grant("R8 favoured hit", 8);
      e_vld[8] = 0;
      do_pick();
      expect_grant("R8 favoured conflict over other hit", 6);

      // R9: favoured thread absent
      cur_tag = "R9";
      clear_entries();
      set_e(1, 1, 3, 99, 2);
      set_e(3, 0, 3, 7, 5);
      do_pick();
      expect_grant("R9 fall back to baseline", 3);

      // R10: held without epoch, same-cycle epoch uses old mode
      cur_tag = "R10";
      clear_entries();
      set_e(0, 2, 3, 99, 30);
      set_e(1, 0, 3, 7, 10);
      set_slow(256, 256, 256, 256);
      do_pick();
      expect_grant("R10 mode held", 0);
      sched_epoch = 1'b1; pick = 1'b1;
      @(negedge clk);
      sched_epoch = 1'b0; pick = 1'b0;
      expect_grant("R10 same-cycle epoch uses old mode", 0);
      do_pick();
      expect_grant("R10 new mode after epoch", 1);

      // R11: threshold write
      cur_tag = "R11";
      write_alpha(1024);
      set_slow(300, 300, 300, 900);
      do_epoch();
      clear_entries();
      set_e(0, 3, 3, 99, 1);
      set_e(1, 0, 3, 7, 2);
      do_pick();
      expect_grant("R11 raised alpha keeps throughput", 1);
      write_alpha(512);
      do_epoch();
      do_pick();
      expect_grant("R11 lowered alpha gives fairness", 0);

      // randomized traffic checked against the model every cycle
      cur_tag = "R3/R5 random";
      for (int n = 0; n < 400; n++) begin
         int base;
         base = $urandom % 256;
         for (int i = 0; i < NE; i++) begin
            e_vld[i]  = ($urandom % 3 != 0) ? 1 : 0;
            e_thr[i]  = $urandom % NT;
            e_bank[i] = $urandom % NB;
            e_row[i]  = $urandom % 4;
            e_age[i]  = (base + ($urandom % 64)) & AMASK;
         end
         for (int b = 0; b < NB; b++) begin
            b_open[b] = $urandom % 2; b_row[b] = $urandom % 4;
         end
         for (int t = 0; t < NT; t++) slow[t] = 64 + ($urandom % 1024);
         pick         = ($urandom % 4 != 0);
         sched_epoch  = ($urandom % 8 == 0);
         cfg_alpha_we = ($urandom % 16 == 0);
         cfg_alpha_wdata = SW'(256 + ($urandom % 1024));
         @(negedge clk);
         pick = 1'b0; sched_epoch = 1'b0; cfg_alpha_we = 1'b0;
      end
      @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule